// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM. A new command, read or write, is taken on every enabled clock edge. Reads and writes may follow each other in any order with no idle cycle between them. Address, write enable, byte selects and the three chip selects are registered at the rising clock edge. Read data leaves through an output register. Write data is taken from the bus at the same pipeline depth as read data, so the shared data bus never needs a dead cycle when its direction changes.

The bidirectional data bus is split into three signals: data in, data out and a drive enable. Chip-level tristate logic combines them. The output-enable pin is asynchronous and gates the drive enable directly. A low clock enable freezes the whole block, as if the previous cycle were stretched. The memory depth and the lane geometry are parameters. The default geometry is 64 words, each made of four 9-bit byte lanes.

Top module: `zt_sram`

## Requirements
- R1: A command is captured on every edge where clkEn is 1, with any mix of reads and writes. A read captured at enabled edge k loads its word into dataOut and raises the internal drive flag at enabled edge k+2, with no wait states.
- R2: A write captured at enabled edge k stores the dataIn value present at enabled edge k+2, not the value present at edge k.
- R3: Lane i covers bits [9i+8:9i] of the word. A write changes lane i only when byteSel[i] is 1; lanes whose select is 0 keep their old contents.
- R4: A read always returns the newest value written to its address, including a write issued in the cycle just before the read.
- R5: When clkEn is 0, all other inputs are ignored. Every pipeline stage, dataOut, the drive flag and the memory contents stay unchanged, and the operation resumes on the next enabled edge as if the stalled cycles had not happened.
- R6: A cycle is a command only when ce1N=0, ce2=1 and ce3N=0. Any other combination is a deselect: it writes nothing and leaves the drive flag low at the stage where read data would appear.
- R7: outEnN=1 forces dataDrive to 0 combinationally, within the same cycle and without a clock edge. It has no effect on the pipeline.
- R8: While rstN is 0, dataDrive is 0. After reset, dataDrive stays 0 until the first read reaches its data stage.
- R9: A write command never drives the bus. dataDrive is 0 at the write's data stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline control |
| clkEn | input | 1 | Clock qualifier; 0 stalls the whole block |
| addr | input | ADDR_W | Word address of the command |
| wrEn | input | 1 | 1 = write command, 0 = read command |
| byteSel | input | LANES | Per-lane write selects, active high |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | LANES*LANE_W | Write data, sampled two enabled edges after its address |
| dataOut | output | LANES*LANE_W | Registered read data |
| dataDrive | output | 1 | 1 when the block drives the data bus |

## Verification
Two functions can fall in the same cycle. The first pair is a clock-enable stall and a write that is waiting for its delayed data. The bench holds clkEn low while a write sits between capture and data stage, and it changes dataIn on every stalled cycle. The second pair is a write and a read of the same address issued back to back, so the read must see the word that the write stores. Both cases are compared, cycle by cycle, against a queue-based reference that counts only enabled edges. The reference therefore decides which dataIn value a write keeps and which value a read returns.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  // strobes handed from the control pipeline to the datapath
  typedef struct packed {
    logic adv;     // pipeline advances on this edge
    logic rdDone;  // a read sits in its data stage
    logic wrDone;  // a write sits in its data stage
  } stageStrobe_t;
endpackage

// File: rtl/zt_sram_ctrl.sv
`timescale 1ns/1ps
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  output stageStrobe_t      strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memLanes
);
  logic              selHit;
  logic              capValid, capWrite;
  logic [ADDR_W-1:0] capAddr;
  logic [LANES-1:0]  capLanes;
  logic              dataValid, dataWrite;
  logic [ADDR_W-1:0] dataAddr;
  logic [LANES-1:0]  dataLanes;

  assign selHit = !ce1N && ce2 && !ce3N;

  // stage 1: command capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capWrite <= 1'b0;
    end else if (clkEn) begin
      capValid <= selHit;
      capWrite <= wrEn;
    end
  end

  always_ff @(posedge clk) begin
    if (clkEn) begin
      capAddr  <= addr;
      capLanes <= byteSel;
    end
  end

  // stage 2: command waits for its data edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      dataWrite <= 1'b0;
    end else if (clkEn) begin
      dataValid <= capValid;
      dataWrite <= capWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (clkEn) begin
      dataAddr  <= capAddr;
      dataLanes <= capLanes;
    end
  end

  always_comb begin
    strb.adv    = clkEn;
    strb.rdDone = dataValid && !dataWrite;
    strb.wrDone = dataValid && dataWrite;
  end

  assign memAddr  = dataAddr;
  assign memLanes = dataLanes;
endmodule

// File: rtl/zt_sram_dp.sv
`timescale 1ns/1ps
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  stageStrobe_t            strb,
  input  logic [ADDR_W-1:0]       memAddr,
  input  logic [LANES-1:0]        memLanes,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    outEnN,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic driveReg;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] outLane;

    // write commits at the data edge, from the bus value of that edge
    always_ff @(posedge clk) begin
      if (strb.adv && strb.wrDone && memLanes[g])
        bank[memAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outLane <= '0;
      else if (strb.adv && strb.rdDone)
        outLane <= bank[memAddr];
    end

    assign dataOut[g*LANE_W +: LANE_W] = outLane;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      driveReg <= 1'b0;
    else if (strb.adv)
      driveReg <= strb.rdDone;
  end

  assign dataDrive = driveReg && !outEnN;
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              outEnN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  stageStrobe_t      strb;
  logic [ADDR_W-1:0] memAddr;
  logic [LANES-1:0]  memLanes;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .wrEn(wrEn),
    .byteSel(byteSel), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .strb(strb), .memAddr(memAddr), .memLanes(memLanes)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memAddr(memAddr),
    .memLanes(memLanes), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              wrEn,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataDrive
);
  logic [1:0] warm;
  logic       cmdHit;

  assign cmdHit = !ce1N && ce2 && !ce3N;

  // edges seen with reset released, saturating at 3
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      warm <= 2'd0;
    else if (warm != 2'd3)
      warm <= warm + 2'd1;
  end

  // R5: a stalled edge leaves the read register alone
  a_r5_hold_out: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(dataOut));

  // R7: output enable high means no drive
  a_r7_oe_gate: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  // R1: read with three enabled edges behind it drives the bus
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(clkEn, 3) && $past(clkEn, 2) && $past(clkEn, 1)
     && $past(cmdHit && !wrEn, 3) && !outEnN) |-> dataDrive);

  // R6: deselect leaves the bus idle at the data stage
  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(clkEn, 3) && $past(clkEn, 2) && $past(clkEn, 1)
     && $past(!cmdHit, 3)) |-> !dataDrive);

  // R9: write never drives at its data stage
  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(clkEn, 3) && $past(clkEn, 2) && $past(clkEn, 1)
     && $past(cmdHit && wrEn, 3)) |-> !dataDrive);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .ce1N(ce1N),
  .ce2(ce2), .ce3N(ce3N), .outEnN(outEnN), .dataOut(dataOut),
  .dataDrive(dataDrive)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEn = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [NL-1:0] byteSel = '0;
  logic          ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic          outEnN = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataDrive;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";

  always #4 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .wrEn(wrEn),
    .byteSel(byteSel), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .outEnN(outEnN), .dataIn(dataIn), .dataOut(dataOut),
    .dataDrive(dataDrive)
  );

  // behavioural reference: queue of commands, counted on enabled edges
  typedef struct {
    bit            hit;
    bit            wr;
    int            a;
    logic [NL-1:0] sel;
  } cmd_t;

  cmd_t          pipeQ[$];
  logic [DW-1:0] refMem [int];
  bit            expDrive = 0;
  bit            expKnown = 0;
  logic [DW-1:0] expData = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      pipeQ.delete();
      expDrive = 0;
    end else if (clkEn) begin
      cmd_t nowCmd;
      nowCmd.hit = (ce1N == 1'b0) && (ce2 == 1'b1) && (ce3N == 1'b0);
      nowCmd.wr  = wrEn;
      nowCmd.a   = int'(addr);
      nowCmd.sel = byteSel;
      pipeQ.push_back(nowCmd);
      if (pipeQ.size() == 3) begin
        cmd_t done;
        done = pipeQ.pop_front();
        expDrive = done.hit && !done.wr;
        if (done.hit && done.wr) begin
          logic [DW-1:0] word;
          word = refMem.exists(done.a) ? refMem[done.a] : '0;
          for (int l = 0; l < NL; l++)
            if (done.sel[l]) word[l*LW +: LW] = dataIn[l*LW +: LW];
          refMem[done.a] = word;
        end
        if (expDrive) begin
          expKnown = refMem.exists(done.a);
          if (expKnown) expData = refMem[done.a];
        end
      end
    end
  end

  task automatic checkOut();
    bit wantDrive;
    wantDrive = rstN && expDrive && !outEnN;
    checks++;
    if (dataDrive !== wantDrive) begin
      errors++;
      $display("FAIL %s dataDrive actual %0b expected %0b", curReq, dataDrive, wantDrive);
    end
    if (rstN && expDrive && expKnown) begin
      checks++;
      if (dataOut !== expData) begin
        errors++;
        $display("FAIL %s dataOut actual %h expected %h", curReq, dataOut, expData);
      end
    end
  endtask

  // badCe < 0 selects the chip; 0..2 spoils one chip select
  task automatic step(input bit en, input bit wr, input int a,
                      input logic [NL-1:0] sel, input int badCe);
    @(negedge clk);
    checkOut();
    clkEn   = en;
    wrEn    = wr;
    addr    = AW'(a);
    byteSel = sel;
    dataIn  = DW'({$urandom(), $urandom()});
    ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    case (badCe)
      0: ce1N = 1'b1;
      1: ce2  = 1'b0;
      2: ce3N = 1'b1;
      default: ;
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, '0, 0);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R8: reset holds the drive low
    curReq = "R8";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (dataDrive !== 1'b0) begin
        errors++;
        $display("FAIL R8 dataDrive in reset actual %0b expected 0", dataDrive);
      end
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(3);

    // R2: full writes to 0..15, data taken at the delayed edge
    curReq = "R2";
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, i, 4'hF, -1);
    idle(2);
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, i, 4'h0, -1);
    idle(2);

    // R1: alternate writes and reads with no gap
    curReq = "R1";
    for (int i = 0; i < 32; i++) begin
      if (i % 2 == 0) step(1'b1, 1'b1, i % 16, 4'hF, -1);
      else            step(1'b1, 1'b0, (i + 3) % 16, 4'h0, -1);
    end
    idle(2);

    // R3: every partial lane mask on one word
    curReq = "R3";
    for (int s = 1; s < 15; s++) begin
      step(1'b1, 1'b1, 5, NL'(s), -1);
      step(1'b1, 1'b0, 5, 4'h0, -1);
    end
    idle(2);

    // R4: read right behind a write, and two writes then a read
    curReq = "R4";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b1, 7, 4'hF, -1);
      step(1'b1, 1'b0, 7, 4'h0, -1);
      step(1'b1, 1'b1, 8, 4'h3, -1);
      step(1'b1, 1'b1, 8, 4'hC, -1);
      step(1'b1, 1'b0, 8, 4'h0, -1);
    end
    idle(2);

    // R5: stall while a read is in flight and while a write waits for data
    curReq = "R5";
    step(1'b1, 1'b0, 2, 4'h0, -1);
    for (int i = 0; i < 5; i++)
      step(1'b0, 1'($urandom()), int'($urandom() % 16), NL'($urandom()), -1);
    idle(3);
    step(1'b1, 1'b1, 3, 4'hF, -1);
    step(1'b1, 1'b0, 3, 4'h0, -1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 3, 4'hF, -1);
    step(1'b1, 1'b0, 3, 4'h0, -1);
    idle(3);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 4, 4'hF, -1);
    step(1'b1, 1'b0, 4, 4'h0, -1);
    idle(3);

    // R6: each spoiled chip select blocks writes and reads
    curReq = "R6";
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, 9, 4'hF, k);
      step(1'b1, 1'b0, 9, 4'h0, k);
      step(1'b1, 1'b0, 9, 4'h0, -1);
      idle(3);
    end

    // R9: back-to-back writes keep the bus idle
    curReq = "R9";
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 10 + i, 4'hF, -1);
    idle(3);

    // R7: output enable gates the drive with no clock edge
    curReq = "R7";
    step(1'b1, 1'b0, 11, 4'h0, -1);
    idle(2);
    @(negedge clk);
    #1 outEnN = 1'b1;
    #1 checks++;
    if (dataDrive !== 1'b0) begin
      errors++;
      $display("FAIL R7 dataDrive with outEnN=1 actual %0b expected 0", dataDrive);
    end
    outEnN = 1'b0;
    #1 checks++;
    if (dataDrive !== 1'b1) begin
      errors++;
      $display("FAIL R7 dataDrive with outEnN=0 actual %0b expected 1", dataDrive);
    end
    outEnN = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 12 + i, 4'h0, -1);
    outEnN = 1'b0;
    idle(3);

    // R1: random mix of reads, writes, stalls and deselects
    curReq = "R1";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom() % 100);
      step(r < 90, 1'($urandom()), int'($urandom() % 16), NL'($urandom()),
           (r % 8 == 0) ? int'($urandom() % 3) : -1);
    end
    idle(4);
    @(negedge clk);
    checkOut();
    finishRun();
  end
endmodule